// File: doc/BRIEF.md
# Cascadable Up/Down Counter with Carry

This block is a synchronous binary counter, four bits wide by default. On each rising clock edge it can be cleared, loaded from a parallel data input, stepped up or down, or held. All of these controls are active low except the direction input. A separate active-low asynchronous clear forces the count to zero at once. The count drives an output bus that can be released to high impedance.

Two count enables gate stepping. The parallel enable only gates the local step. The trickle enable also qualifies the ripple carry, which marks the terminal count for the current direction: all ones when counting up, zero when counting down. To build a wider counter, feed each stage's ripple carry into the trickle enable of the next stage.

A clocked carry output gives one low pulse for each qualifying cycle, and the pulse is confined to the low phase of the clock.

Top module: `updown_carry_counter`

## Requirements
- R1: While `arst_n` is low the count is 0 at once, with no clock edge needed.
- R2: With `sclr_n` low, the next rising edge makes the count 0, whatever the load, enables and direction.
- R3: With `sclr_n` high and `load_n` low, the next rising edge copies `din` into the count, whatever the enables and direction.
- R4: With `sclr_n` and `load_n` high, the count holds on an edge unless `en_par_n` and `en_trk_n` are both low.
- R5: When stepping is enabled, `dir_up` = 1 adds one and `dir_up` = 0 subtracts one, modulo 2^WIDTH (all ones wraps to 0, 0 wraps to all ones).
- R6: `rco_n` is 0 exactly when `en_trk_n` is 0 and the count is at its terminal value: all ones with `dir_up` = 1, or 0 with `dir_up` = 0. `en_par_n` has no effect on it.
- R7: `cco_n` is 0 only while `clk` is 0 and both `rco_n` and `en_par_n` are 0. It is 1 in every other case.
- R8: With `oe_n` = 1 every bit of `q` is high impedance. With `oe_n` = 0, `q` shows the count. `oe_n` changes neither the count nor the carries.
- R9: When two stages are chained (`rco_n` of the low stage into `en_trk_n` of the high stage), they form a counter of twice the width. The high stage steps only on the low stage's terminal count, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| arst_n | input | 1 | Asynchronous clear, active low |
| sclr_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Parallel load, active low |
| din | input | WIDTH | Parallel load data |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| en_par_n | input | 1 | Parallel count enable, active low |
| en_trk_n | input | 1 | Trickle count enable, active low; also qualifies the carries |
| oe_n | input | 1 | Output enable, active low; high releases `q` |
| q | output | WIDTH | Count output, tri-stated when disabled |
| rco_n | output | 1 | Ripple carry, active low |
| cco_n | output | 1 | Clocked carry, active low during the clock low phase |

## Verification
The hardest case to reach from the ports is the terminal count combined with each enable pattern in both directions. This is where the ripple and clocked carries are each asserted or suppressed, and where a two-stage chain hands its carry across a wrap. The bench sweeps every load value. For each value it applies all four enable combinations in both directions and checks the carries during the low clock phase before the edge, then checks the count after the edge. A chained pair then runs continuously up past a full 8-bit wrap and back down past another, and each cycle is compared with arithmetic modulo 256.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_UP    = 3'd3,
    OP_DOWN  = 3'd4
  } ctr_op_e;
endpackage

// File: rtl/ctr_op_sel.sv
module ctr_op_sel
  import ctr_pkg::*;
(
  input  logic    sclr_n,
  input  logic    load_n,
  input  logic    en_par_n,
  input  logic    en_trk_n,
  input  logic    dir_up,
  output ctr_op_e op
);
  logic step_ok;
  assign step_ok = ~en_par_n & ~en_trk_n;

  // priority: synchronous clear, then load, then step, else hold
  always_comb begin
    if (!sclr_n)      op = OP_CLEAR;
    else if (!load_n) op = OP_LOAD;
    else if (step_ok) op = dir_up ? OP_UP : OP_DOWN;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/ctr_state.sv
module ctr_state
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             arst_n,
  input  ctr_op_e          op,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count
);
  function automatic logic [WIDTH-1:0] step_val(input logic [WIDTH-1:0] v,
                                                input logic up);
    logic [WIDTH-1:0] one;
    one = {{(WIDTH-1){1'b0}}, 1'b1};
    return up ? (v + one) : (v - one);
  endfunction

  logic [WIDTH-1:0] nxt;

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_UP:    nxt = step_val(count, 1'b1);
      OP_DOWN:  nxt = step_val(count, 1'b0);
      default:  nxt = count;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) count <= '0;
    else         count <= nxt;
  end
endmodule

// File: rtl/ctr_carry.sv
module ctr_carry #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] count,
  input  logic             dir_up,
  input  logic             en_par_n,
  input  logic             en_trk_n,
  output logic             term_hit,
  output logic             rco_n,
  output logic             cco_n
);
  function automatic logic at_terminal(input logic [WIDTH-1:0] v,
                                       input logic up);
    return up ? (&v) : ~(|v);
  endfunction

  assign term_hit = at_terminal(count, dir_up);
  assign rco_n    = ~(term_hit & ~en_trk_n);
  assign cco_n    = ~(~clk & ~rco_n & ~en_par_n);
endmodule

// File: rtl/updown_carry_counter.sv
module updown_carry_counter
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             sclr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             dir_up,
  input  logic             en_par_n,
  input  logic             en_trk_n,
  input  logic             oe_n,
  output logic [WIDTH-1:0] q,
  output logic             rco_n,
  output logic             cco_n
);
  ctr_op_e          op;
  logic [WIDTH-1:0] count;
  logic             term_hit;

  ctr_op_sel u_sel (
    .sclr_n  (sclr_n),
    .load_n  (load_n),
    .en_par_n(en_par_n),
    .en_trk_n(en_trk_n),
    .dir_up  (dir_up),
    .op      (op)
  );

  ctr_state #(.WIDTH(WIDTH)) u_state (
    .clk   (clk),
    .arst_n(arst_n),
    .op    (op),
    .din   (din),
    .count (count)
  );

  ctr_carry #(.WIDTH(WIDTH)) u_carry (
    .clk     (clk),
    .count   (count),
    .dir_up  (dir_up),
    .en_par_n(en_par_n),
    .en_trk_n(en_trk_n),
    .term_hit(term_hit),
    .rco_n   (rco_n),
    .cco_n   (cco_n)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_drv
    assign q[i] = oe_n ? 1'bz : count[i];
  end
endmodule

// File: rtl/ctr_checker.sv
module ctr_checker
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             arst_n,
  input logic             sclr_n,
  input logic             en_par_n,
  input logic             en_trk_n,
  input logic             dir_up,
  input logic [WIDTH-1:0] din,
  input ctr_op_e          op,
  input logic [WIDTH-1:0] count,
  input logic             term_hit,
  input logic             rco_n,
  input logic             cco_n
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!arst_n) assert_async_zero_R1: assert (count == '0);
  end

  assert_sync_clear_R2: assert property (@(posedge clk) disable iff (!arst_n)
    !sclr_n |=> count == '0);

  assert_load_R3: assert property (@(posedge clk) disable iff (!arst_n)
    op == OP_LOAD |=> count == $past(din));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!arst_n)
    op == OP_HOLD |=> $stable(count));

  assert_up_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (sclr_n && op == OP_UP && dir_up && !en_par_n && !en_trk_n) |=> count == $past(count) + ONE);

  assert_down_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (sclr_n && op == OP_DOWN && !dir_up && !en_par_n && !en_trk_n) |=> count == $past(count) - ONE);

  assert_rco_R6: assert property (@(posedge clk) disable iff (!arst_n)
    !rco_n |-> (term_hit && !en_trk_n));

  always_comb begin
    if (arst_n && cco_n == 1'b0)
      assert_cco_low_R7: assert (!clk && !rco_n && !en_par_n);
  end
endmodule

bind updown_carry_counter ctr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .arst_n  (arst_n),
  .sclr_n  (sclr_n),
  .en_par_n(en_par_n),
  .en_trk_n(en_trk_n),
  .dir_up  (dir_up),
  .din     (din),
  .op      (op),
  .count   (count),
  .term_hit(term_hit),
  .rco_n   (rco_n),
  .cco_n   (cco_n)
);

// File: tb/test_updown_carry_counter.sv
`timescale 1ns/1ps
module test_updown_carry_counter;
  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       sclr_n = 1'b1, load_n = 1'b1, dir_up = 1'b1;
  logic       en_par_n = 1'b1, en_trk_n = 1'b1, oe_n = 1'b0;
  logic [3:0] din = 4'd0;
  wire  [3:0] q;
  wire        rco_n, cco_n;

  int vectors = 0;
  int fails   = 0;
  int exp_cnt = 0;

  always #5 clk = ~clk;

  updown_carry_counter #(.WIDTH(4)) i_updown_carry_counter (
    .clk(clk), .arst_n(arst_n), .sclr_n(sclr_n), .load_n(load_n), .din(din),
    .dir_up(dir_up), .en_par_n(en_par_n), .en_trk_n(en_trk_n), .oe_n(oe_n),
    .q(q), .rco_n(rco_n), .cco_n(cco_n)
  );

  // two-stage chain for R9
  logic       c_sclr_n = 1'b1, c_dir = 1'b1, c_ep_n = 1'b1;
  wire  [3:0] lo_q, hi_q;
  wire        lo_rco_n, hi_rco_n, lo_cco_n, hi_cco_n;

  updown_carry_counter #(.WIDTH(4)) i_stage_lo (
    .clk(clk), .arst_n(arst_n), .sclr_n(c_sclr_n), .load_n(1'b1), .din(4'd0),
    .dir_up(c_dir), .en_par_n(c_ep_n), .en_trk_n(1'b0), .oe_n(1'b0),
    .q(lo_q), .rco_n(lo_rco_n), .cco_n(lo_cco_n)
  );
  updown_carry_counter #(.WIDTH(4)) i_stage_hi (
    .clk(clk), .arst_n(arst_n), .sclr_n(c_sclr_n), .load_n(1'b1), .din(4'd0),
    .dir_up(c_dir), .en_par_n(c_ep_n), .en_trk_n(lo_rco_n), .oe_n(1'b0),
    .q(hi_q), .rco_n(hi_rco_n), .cco_n(hi_cco_n)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_next(input int e, input logic s_n, input logic l_n,
                                    input int d, input logic up, input logic ep,
                                    input logic et);
    if (!s_n) return 0;
    if (!l_n) return d;
    if (!ep && !et) return up ? (e + 1) % 16 : (e + 15) % 16;
    return e;
  endfunction

  function automatic int model_rco(input int e, input logic up, input logic et);
    return (!et && ((up && e == 15) || (!up && e == 0))) ? 0 : 1;
  endfunction

  // inputs are applied just after a rising edge; carries are checked in the
  // low phase, the count and the idle clocked carry after the next edge
  task automatic apply(input string req, input logic s_n, input logic l_n,
                       input int d, input logic up, input logic ep, input logic et);
    int rexp;
    sclr_n = s_n; load_n = l_n; din = d[3:0]; dir_up = up;
    en_par_n = ep; en_trk_n = et;
    @(negedge clk); #1;
    rexp = model_rco(exp_cnt, up, et);
    check("R6 rco_n", int'(rco_n), rexp);
    check("R7 cco_n low phase", int'(cco_n), (rexp == 0 && !ep) ? 0 : 1);
    exp_cnt = model_next(exp_cnt, s_n, l_n, d, up, ep, et);
    @(posedge clk); #1;
    check({req, " count"}, int'(q), exp_cnt);
    check("R7 cco_n high phase", int'(cco_n), 1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset count", int'(q), 0);
    check("R6 rco_n reset", int'(rco_n), 1);
    check("R7 cco_n reset", int'(cco_n), 1);
    arst_n = 1'b1;
    @(posedge clk); #1;

    // sweep all values, both directions, all enable pairs
    for (int v = 0; v < 16; v++) begin
      for (int dir = 0; dir < 2; dir++) begin
        for (int en = 0; en < 4; en++) begin
          // R3: load ignores enables and direction
          apply("R3 load", 1'b1, 1'b0, v, logic'(v[1]), logic'(v[0]), logic'(v[2]));
          apply(en == 0 ? "R5 step" : "R4 hold", 1'b1, 1'b1, 0, logic'(dir),
                logic'(en[0]), logic'(en[1]));
        end
      end
    end

    // terminal values with parallel enable off: ripple carry still low (R6)
    apply("R3 load", 1'b1, 1'b0, 15, 1'b1, 1'b1, 1'b1);
    apply("R4 hold par off", 1'b1, 1'b1, 0, 1'b1, 1'b1, 1'b0);
    apply("R3 load", 1'b1, 1'b0, 0, 1'b0, 1'b1, 1'b1);
    apply("R4 hold par off", 1'b1, 1'b1, 0, 1'b0, 1'b1, 1'b0);

    // R2: synchronous clear beats load and count
    apply("R3 load", 1'b1, 1'b0, 9, 1'b1, 1'b0, 1'b0);
    apply("R2 sclr over load", 1'b0, 1'b0, 5, 1'b1, 1'b0, 1'b0);
    apply("R3 load", 1'b1, 1'b0, 7, 1'b1, 1'b0, 1'b0);
    apply("R2 sclr over count", 1'b0, 1'b1, 0, 1'b0, 1'b0, 1'b0);

    // R8: outputs released, state keeps running
    apply("R3 load", 1'b1, 1'b0, 14, 1'b1, 1'b1, 1'b1);
    oe_n = 1'b1;
    #1;
    vectors++;
    if (q !== 4'bzzzz) begin
      fails++;
      $display("FAIL R8 q released: actual %b expected zzzz", q);
    end
    sclr_n = 1'b1; load_n = 1'b1; dir_up = 1'b1; en_par_n = 1'b0; en_trk_n = 1'b0;
    @(negedge clk); #1;
    check("R8 rco_n while released", int'(rco_n), 1);
    @(posedge clk); #1;
    @(negedge clk); #1;
    check("R8 rco_n at 15 while released", int'(rco_n), 0);
    check("R8 cco_n at 15 while released", int'(cco_n), 0);
    vectors++;
    if (q !== 4'bzzzz) begin
      fails++;
      $display("FAIL R8 q still released: actual %b expected zzzz", q);
    end
    en_par_n = 1'b1;
    @(posedge clk); #1;
    oe_n = 1'b0;
    #1;
    check("R8 count after re-enable", int'(q), 15);
    exp_cnt = 15;

    // R1: asynchronous clear mid-cycle
    apply("R3 load", 1'b1, 1'b0, 9, 1'b1, 1'b1, 1'b1);
    @(negedge clk); #2;
    arst_n = 1'b0;
    #1;
    check("R1 async clear before edge", int'(q), 0);
    @(posedge clk); #1;
    arst_n = 1'b1;
    exp_cnt = 0;
    check("R1 held zero", int'(q), 0);

    // R9: chained pair, up through 8-bit wrap then down through wrap
    c_sclr_n = 1'b0;
    @(posedge clk); #1;
    c_sclr_n = 1'b1;
    check("R9 chain cleared", int'({hi_q, lo_q}), 0);
    c_dir = 1'b1; c_ep_n = 1'b0;
    for (int n = 1; n <= 300; n++) begin
      @(posedge clk); #1;
      check("R9 chain up", int'({hi_q, lo_q}), n % 256);
    end
    c_dir = 1'b0;
    for (int n = 1; n <= 300; n++) begin
      @(posedge clk); #1;
      check("R9 chain down", int'({hi_q, lo_q}), (300 - n + 256 * 2) % 256);
    end
    c_ep_n = 1'b1;
    @(posedge clk); #1;
    check("R9 chain hold", int'({hi_q, lo_q}), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule